// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block gathers eleven internal interrupt requests and four external request pins and tells the processor core which one to service. Every internal source is given a priority level from 1 to 7, a high or low rank within that level, a mask bit and an autovector flag. The external pins do not have their own level registers. One configuration bit selects which fixed set of levels they use, and each pin can be set to level-sensitive or falling-edge-latched operation.

On every clock the controller picks one winner among the eligible sources. A source is eligible when it is requesting, it is not masked, and its level is 7 or above the core's mask level. The winner goes to a registered output as a 3-bit level code, a source number and an autovector flag. When the core acknowledges an edge-latched external pin while that pin is the presented source, the latch for that pin is cleared. Configuration is written through a simple write strobe, address and data interface.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the outputs show no request: `irq_level` = 0, `irq_src` = 15, `irq_auto` = 0.
- R2: A write at addresses 0 to 10 sets the fields of that internal source: bits [2:0] level (0 keeps the source out), bit 3 sub-priority (1 = high), bit 4 autovector, bit 5 mask (1 = masked). Address 11 sets bit 0 external level set and bits [7:4] edge mode for pins 0 to 3. Address 12 bits [3:0] set autovector for pins 0 to 3. Writes to any other address change nothing. A write takes effect at the outputs one clock after its strobe edge.
- R3: The output level is the highest level among eligible sources. It is registered, so a change on `int_req` shows one clock edge later.
- R4: At equal level a high sub-priority source beats a low one. At equal level and sub-priority the lowest source number wins. Internal source i has number i; external pin j has number 11+j and low sub-priority.
- R5: A masked internal source, or one with level 0, never wins.
- R6: Levels 1 to 6 are presented only when above `mask_level`. Level 7 is presented whatever `mask_level` is.
- R7: External pins are active low. With set bit 0, pin j has level 2j+1 (1,3,5,7). With set bit 1, pins 0 to 3 have levels 2,4,6,7.
- R8: An external pin passes through two synchronizer flops, so its effect shows three clock edges after the pin changes.
- R9: A pin in edge mode latches a pending request on its falling edge. The request stays after the pin returns high, and it is cleared by `ack` sampled while that pin is the presented source. The outputs go idle one edge after the ack edge.
- R10: `ack` has no effect on internal sources or on level-mode pins.
- R11: `irq_auto` equals the autovector setting of the presented source.
- R12: When no source is eligible, `irq_src` is 15 and `irq_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_req | input | 11 | Internal requests, active high, level |
| ext_req_n | input | 4 | External request pins, active low, asynchronous |
| mask_level | input | 3 | Core interrupt mask level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| ack | input | 1 | Acknowledge of the presented source |
| irq_level | output | 3 | Presented level, 0 = none |
| irq_src | output | 4 | Presented source number, 15 = none |
| irq_auto | output | 1 | Autovector flag of the presented source |

## Verification
Changes on internal requests, mask level and configuration are due one clock edge after they are sampled. External pin changes are due after three edges. An ack clears an edge latch at its own edge, and the idle outputs appear one edge later. The bench drives inputs on falling edges and samples outputs on the following falling edges. Its directed checks wait the exact number of edges for each path, including an early sample taken before an external request can have arrived. A behavioural model follows the same timing and is compared with the outputs on every cycle, under both directed and random stimulus.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_INT = 11,
  parameter int AW    = 4,
  parameter int SW    = $clog2(N_INT + 5)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_INT-1:0] int_req,
  input  logic [3:0]       ext_req_n,
  input  logic [2:0]       mask_level,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             ack,
  output logic [2:0]       irq_level,
  output logic [SW-1:0]    irq_src,
  output logic             irq_auto
);
  localparam int NX = 4;
  localparam int NS = N_INT + NX;
  localparam logic [SW-1:0] IDLE = '1;
  localparam logic [AW-1:0] A_XCTL = AW'(N_INT);
  localparam logic [AW-1:0] A_XAV  = AW'(N_INT + 1);

  logic [2:0]       lvl_q [N_INT];
  logic [N_INT-1:0] sub_q, av_q, msk_q;
  logic             ext_sel_q;
  logic [NX-1:0]    ext_edge_q, ext_av_q;
  logic [NX-1:0]    s1_q, s2_q, pend_q;

  logic [2:0]    src_lvl [NS];
  logic [NS-1:0] src_ok, src_sub, src_av;

  for (genvar i = 0; i < N_INT; i++) begin : g_int
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lvl_q[i] <= '0;
        sub_q[i] <= 1'b0;
        av_q[i]  <= 1'b0;
        msk_q[i] <= 1'b0;
      end else if (cfg_we && cfg_addr == AW'(i)) begin
        lvl_q[i] <= cfg_wdata[2:0];
        sub_q[i] <= cfg_wdata[3];
        av_q[i]  <= cfg_wdata[4];
        msk_q[i] <= cfg_wdata[5];
      end

    assign src_lvl[i] = lvl_q[i];
    assign src_sub[i] = sub_q[i];
    assign src_av[i]  = av_q[i];
    assign src_ok[i]  = int_req[i] && !msk_q[i] && lvl_q[i] != 3'd0 &&
                        (lvl_q[i] == 3'd7 || lvl_q[i] > mask_level);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_sel_q  <= 1'b0;
      ext_edge_q <= '0;
      ext_av_q   <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_XCTL) begin
        ext_sel_q  <= cfg_wdata[0];
        ext_edge_q <= cfg_wdata[7:4];
      end
      if (cfg_addr == A_XAV) ext_av_q <= cfg_wdata[3:0];
    end

  for (genvar j = 0; j < NX; j++) begin : g_ext
    localparam logic [2:0] LV_A = 3'(2 * j + 1);
    localparam logic [2:0] LV_B = (j == NX - 1) ? 3'd7 : 3'(2 * j + 2);
    localparam logic [SW-1:0] MY_ID = SW'(N_INT + j);
    logic act, fall, clr;

    assign fall = !s1_q[j] && s2_q[j];
    assign clr  = ack && irq_src == MY_ID;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        s1_q[j]   <= 1'b1;
        s2_q[j]   <= 1'b1;
        pend_q[j] <= 1'b0;
      end else begin
        s1_q[j]   <= ext_req_n[j];
        s2_q[j]   <= s1_q[j];
        pend_q[j] <= ext_edge_q[j] && (fall || (pend_q[j] && !clr));
      end

    assign act = ext_edge_q[j] ? pend_q[j] : !s2_q[j];
    assign src_lvl[N_INT+j] = ext_sel_q ? LV_B : LV_A;
    assign src_sub[N_INT+j] = 1'b0;
    assign src_av[N_INT+j]  = ext_av_q[j];
    assign src_ok[N_INT+j]  = act &&
      (src_lvl[N_INT+j] == 3'd7 || src_lvl[N_INT+j] > mask_level);
  end

  logic [3:0]    best_key;
  logic [SW-1:0] best_id;
  logic          best_av;

  always_comb begin
    best_key = '0;
    best_id  = IDLE;
    best_av  = 1'b0;
    for (int i = 0; i < NS; i++)
      if (src_ok[i] && {src_lvl[i], src_sub[i]} > best_key) begin
        best_key = {src_lvl[i], src_sub[i]};
        best_id  = SW'(i);
        best_av  = src_av[i];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_level <= '0;
      irq_src   <= IDLE;
      irq_auto  <= 1'b0;
    end else begin
      irq_level <= best_key[3:1];
      irq_src   <= best_id;
      irq_auto  <= best_av;
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_INT = 11,
  parameter int SW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_INT-1:0] int_req,
  input logic [2:0]       mask_level,
  input logic             ext_sel_q,
  input logic [2:0]       irq_level,
  input logic [SW-1:0]    irq_src,
  input logic             irq_auto
);
  function automatic logic [2:0] ext_lvl(input logic sel, input logic [SW-1:0] id);
    int j;
    j = int'(id) - N_INT;
    if (sel) return (j == 3) ? 3'd7 : 3'(2 * j + 2);
    return 3'(2 * j + 1);
  endfunction

  a_r12_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == 3'd0 |-> irq_src == '1 && !irq_auto);

  a_r6_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != 3'd0 |-> irq_level == 3'd7 || irq_level > $past(mask_level));

  a_r3_int_src_requested: assert property (@(posedge clk) disable iff (!rst_n)
    int'(irq_src) < N_INT |-> |($past(int_req) & (N_INT'(1) << irq_src)));

  a_r7_ext_level_map: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(irq_src) >= N_INT && int'(irq_src) < N_INT + 4) |->
      irq_level == ext_lvl($past(ext_sel_q), irq_src));

  a_r11_auto_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_auto |-> irq_level != 3'd0);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_INT(N_INT), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_req(int_req), .mask_level(mask_level),
  .ext_sel_q(ext_sel_q), .irq_level(irq_level), .irq_src(irq_src),
  .irq_auto(irq_auto)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] int_req = '0;
  logic [3:0]  ext_req_n = 4'hF;
  logic [2:0]  mask_level = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        ack = 1'b0;
  logic [2:0]  irq_level;
  logic [3:0]  irq_src;
  logic        irq_auto;

  int checks = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .ext_req_n(ext_req_n),
    .mask_level(mask_level), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ack(ack), .irq_level(irq_level),
    .irq_src(irq_src), .irq_auto(irq_auto)
  );

  // behavioural reference model
  int m_lvl[11], m_sub[11], m_av[11], m_msk[11];
  bit m_sel;
  bit [3:0] m_edge, m_eav, m_s1, m_s2, m_pend;
  int e_lvl = 0, e_src = 15, e_av = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_lvl[i]) begin m_lvl[i] = 0; m_sub[i] = 0; m_av[i] = 0; m_msk[i] = 0; end
      m_sel = 0; m_edge = 0; m_eav = 0; m_s1 = 4'hF; m_s2 = 4'hF; m_pend = 0;
      e_lvl = 0; e_src = 15; e_av = 0;
    end else begin
      int bk, bs, ba, mk;
      bit [3:0] np;
      mk = int'(mask_level);
      bk = 0; bs = 15; ba = 0;
      for (int i = 0; i < 15; i++) begin
        int l, s, a;
        bit ok;
        if (i < 11) begin
          l = m_lvl[i]; s = m_sub[i]; a = m_av[i];
          ok = int_req[i] && m_msk[i] == 0 && l != 0;
        end else begin
          int j;
          j = i - 11;
          l = m_sel ? ((j == 3) ? 7 : 2 * j + 2) : 2 * j + 1;
          s = 0; a = m_eav[j];
          ok = m_edge[j] ? m_pend[j] : !m_s2[j];
        end
        ok = ok && (l == 7 || l > mk);
        if (ok && l * 2 + s > bk) begin bk = l * 2 + s; bs = i; ba = a; end
      end
      for (int j = 0; j < 4; j++) begin
        bit fall, keep;
        fall = !m_s1[j] && m_s2[j];
        keep = m_pend[j] && !(ack && e_src == 11 + j);
        np[j] = m_edge[j] && (fall || keep);
      end
      m_pend = np;
      m_s2 = m_s1;
      m_s1 = ext_req_n;
      if (cfg_we) begin
        if (cfg_addr < 11) begin
          m_lvl[cfg_addr] = cfg_wdata[2:0]; m_sub[cfg_addr] = cfg_wdata[3];
          m_av[cfg_addr] = cfg_wdata[4]; m_msk[cfg_addr] = cfg_wdata[5];
        end else if (cfg_addr == 11) begin
          m_sel = cfg_wdata[0]; m_edge = cfg_wdata[7:4];
        end else if (cfg_addr == 12) m_eav = cfg_wdata[3:0];
      end
      e_lvl = bk / 2; e_src = bs; e_av = ba;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(int'(irq_level) == e_lvl, "R3 model level", irq_level, e_lvl);
    chk(int'(irq_src) == e_src, "R4 model source", irq_src, e_src);
    chk(int'(irq_auto) == e_av, "R11 model autovector", irq_auto, e_av);
  end

  task automatic expect_out(input string tag, input int l, input int s, input int a);
    chk(int'(irq_level) == l, {tag, " level"}, irq_level, l);
    chk(int'(irq_src) == s, {tag, " source"}, irq_src, s);
    chk(int'(irq_auto) == a, {tag, " auto"}, irq_auto, a);
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    expect_out("R1 in reset", 0, 15, 0);
    rst_n = 1'b1;
    step(1);
    expect_out("R1 after reset", 0, 15, 0);
    expect_out("R12 idle", 0, 15, 0);

    wr(3, 8'h14);
    int_req[3] = 1'b1; step(1);
    expect_out("R3 single source", 4, 3, 1);
    expect_out("R11 autovector on", 4, 3, 1);

    wr(5, 8'h0C);
    int_req[5] = 1'b1; step(1);
    expect_out("R4 high sub-priority", 4, 5, 0);

    wr(2, 8'h04);
    int_req[2] = 1'b1; int_req[5] = 1'b0; step(1);
    expect_out("R4 lowest index tie", 4, 2, 0);

    wr(7, 8'h26);
    int_req[7] = 1'b1; int_req[9] = 1'b1; step(1);
    expect_out("R5 masked and level 0 ignored", 4, 2, 0);

    mask_level = 3'd4; step(1);
    expect_out("R6 level at mask hidden", 0, 15, 0);
    wr(8, 8'h07);
    int_req[8] = 1'b1; mask_level = 3'd7; step(1);
    expect_out("R6 level 7 unmaskable", 7, 8, 0);

    wr(13, 8'hFF);
    step(1);
    expect_out("R2 unused address ignored", 7, 8, 0);
    int_req = '0; mask_level = 3'd0;
    wr(3, 8'h12);
    int_req[3] = 1'b1; step(1);
    expect_out("R2 rewrite level", 2, 3, 1);
    int_req = '0; step(1);

    wr(12, 8'h04);
    ext_req_n = 4'b1011;
    step(1); expect_out("R8 one edge", 0, 15, 0);
    step(1); expect_out("R8 two edges", 0, 15, 0);
    step(1); expect_out("R8 three edges", 5, 13, 1);
    expect_out("R7 set A pin 2", 5, 13, 1);
    wr(11, 8'h01); step(1);
    expect_out("R7 set B pin 2", 6, 13, 1);
    ext_req_n = 4'b0011; step(3);
    expect_out("R7 set B pin 3", 7, 14, 0);
    ext_req_n = 4'hF; step(3);
    expect_out("R12 pins released", 0, 15, 0);

    wr(11, 8'h20);
    ext_req_n = 4'b1101; step(1);
    ext_req_n = 4'hF; step(2);
    expect_out("R9 edge latched", 3, 12, 0);
    step(3);
    expect_out("R9 latch held", 3, 12, 0);
    ack = 1'b1; step(1); ack = 1'b0;
    expect_out("R9 ack pipeline", 3, 12, 0);
    step(1);
    expect_out("R9 ack cleared", 0, 15, 0);

    int_req[3] = 1'b1; step(1);
    ack = 1'b1; step(1); ack = 1'b0; step(1);
    expect_out("R10 ack internal", 2, 3, 1);
    int_req = '0; wr(11, 8'h00);
    ext_req_n = 4'b1110; step(3);
    ack = 1'b1; step(1); ack = 1'b0; step(1);
    expect_out("R10 ack level pin", 1, 11, 0);
    ext_req_n = 4'hF; step(3);

    for (int k = 0; k < 3000; k++) begin
      int_req = 11'($urandom);
      if ($urandom_range(0, 3) == 0) ext_req_n = 4'($urandom);
      mask_level = 3'($urandom_range(0, 7));
      ack = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 5) == 0) begin
        cfg_we = 1'b1; cfg_addr = 4'($urandom_range(0, 14)); cfg_wdata = 8'($urandom);
      end else cfg_we = 1'b0;
      step(1);
    end
    cfg_we = 1'b0; ack = 1'b0;
    step(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; bad++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule